// File: doc/BRIEF.md
# Oversampled serial receiver with selectable stop field

This block recovers bytes from an asynchronous serial line. It uses an enable pulse that arrives sixteen times per bit period. It waits for a falling edge, confirms the start bit, and then shifts in eight data bits, least significant first. Every bit level, including the start and stop levels, is decided by a 2-of-3 vote over three consecutive oversampling ticks.

The stop field can be half a bit, one bit, one and a half bits or two bits long. In the longer smartcard-style setting, the first half bit is skipped and the line is sampled one full bit after the stop field begins. A card that pulls the line low at that point to refuse a character is therefore reported as a framing error.

Each completed frame loads the byte into a data register and raises a valid flag. A framing error raises a sticky error flag in the same cycle, and the byte is stored anyway. A read strobe drops the valid flag. Only a dedicated clear strobe drops the error flag.

Top module: `uart_stop_rx`

## Requirements
- R1: After reset `rx_valid` and `rx_fe` are 0 and `rx_data` is 0.
- R2: Data bits are taken least significant bit first. Each bit is the majority of oversampling ticks 8, 9 and 10 of its bit period, so a single inverted tick does not change the bit.
- R3: A low level that is not low by majority at ticks 8 to 10 of the start bit is a false start. The receiver returns to idle and delivers no byte.
- R4: `stop_sel` encoding: 00 selects one stop bit, 01 half a bit, 10 two bits and 11 one and a half bits. `rx_valid` rises on the tick that ends the checked part of the stop field. That tick is stop tick 16 for 00 and 10, tick 8 for 01 and tick 24 for 11, counted from the first tick of the stop field.
- R5: With one stop bit, the line is sampled at stop ticks 8, 9 and 10. A low majority there is a framing error, and a single low tick is not.
- R6: With one and a half stop bits, the line is sampled at stop ticks 16, 17 and 18. A low level during stop ticks 1 to 8 is ignored, and a low majority at ticks 16 to 18 (a refusal from the card) is a framing error.
- R7: With half a stop bit, the stop field is never sampled and no framing error is ever raised.
- R8: With two stop bits, only the first stop bit is sampled, at ticks 8 to 10. A low second stop bit raises no error and starts no frame.
- R9: On a framing error the received byte is still loaded into `rx_data`, and `rx_fe` rises in the same cycle as `rx_valid`.
- R10: `rx_fe` is sticky. `rd_stb` leaves it set, and only a one on `fe_clr` clears it.
- R11: A pulse on `rd_stb` clears `rx_valid` on the next clock.
- R12: After a frame the receiver stays idle until a high-to-low transition on the line. A line that is still low when the stop field ends starts no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| stop_sel | input | 2 | Stop field selection (see R4) |
| rd_stb | input | 1 | Data read strobe, clears the valid flag |
| fe_clr | input | 1 | Write-one strobe that clears the framing error flag |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_fe | output | 1 | Sticky framing error flag |

## Verification
The hardest situations to reach are those where the line level at one specific tick of the stop field decides the outcome:
- the refusal pulse that lands only on ticks 16 to 18 of a one-and-a-half-bit stop;
- a single low tick inside the one-bit voting window;
- a line that is still low when a half-bit or second stop bit ends.

The driver therefore builds every frame tick by tick and takes the stop field as a 32-tick level vector. This lets each case place low ticks exactly where it needs them. The scoreboard records the absolute tick at which each byte must appear and compares it with the tick count at the moment `rx_valid` rises.

// File: rtl/uart_srx_pkg.sv
package uart_srx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_HALF     = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_ONE_HALF = 2'b11
    } stop_mode_e;

endpackage

// File: rtl/uart_srx_sync.sv
module uart_srx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = d_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {STAGES{RST_VAL}};
        else        sync_q <= sync_d;
    end

    assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/uart_srx_vote.sv
module uart_srx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    input  logic bit_i,
    output logic maj_o
);

    logic [2:0] samp_d, samp_q;

    always_comb begin
        samp_d = cap_i ? {samp_q[1:0], bit_i} : samp_q;
        maj_o  = (samp_q[0] & samp_q[1]) | (samp_q[0] & samp_q[2]) |
                 (samp_q[1] & samp_q[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= 3'b111;
        else        samp_q <= samp_d;
    end

endmodule

// File: rtl/uart_srx_fsm.sv
module uart_srx_fsm
    import uart_srx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              maj_i,
    input  stop_mode_e        mode_i,
    output logic              cap_o,
    output logic              load_o,
    output logic              load_fe_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int CNT_W = $clog2(2 * OVS + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] T_MID     = CNT_W'(OVS / 2);
    localparam logic [CNT_W-1:0] T_FULL    = CNT_W'(OVS);
    localparam logic [CNT_W-1:0] T_ONEHALF = CNT_W'(OVS + OVS / 2);
    localparam logic [CNT_W-1:0] T_TWO     = CNT_W'(2 * OVS);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              prev;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [CNT_W-1:0] tick_no, win_lo, load_at, end_at;
    logic check_en, in_win;

    always_comb begin
        tick_no  = r_q.cnt + 1'b1;
        win_lo   = T_MID;
        check_en = 1'b1;
        load_at  = T_FULL;
        end_at   = T_FULL;
        if (r_q.state == ST_STOP) begin
            unique case (mode_i)
                STOP_HALF: begin
                    check_en = 1'b0;
                    load_at  = T_MID;
                    end_at   = T_MID;
                end
                STOP_ONE_HALF: begin
                    win_lo  = T_FULL;
                    load_at = T_ONEHALF;
                    end_at  = T_ONEHALF;
                end
                STOP_TWO: end_at = T_TWO;
                default: ;
            endcase
        end
        in_win = check_en && (r_q.state != ST_IDLE) &&
                 (tick_no >= win_lo) && (tick_no <= win_lo + CNT_W'(2));
        cap_o  = tick_i && in_win;

        r_d       = r_q;
        load_o    = 1'b0;
        load_fe_o = 1'b0;
        if (tick_i) begin
            r_d.prev = rx_i;
            case (r_q.state)
                ST_IDLE: begin
                    if (r_q.prev && !rx_i) begin
                        r_d.state = ST_START;
                        r_d.cnt   = CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (tick_no == T_FULL) begin
                        r_d.cnt   = '0;
                        r_d.idx   = '0;
                        r_d.state = maj_i ? ST_IDLE : ST_DATA;
                    end else begin
                        r_d.cnt = tick_no;
                    end
                end
                ST_DATA: begin
                    if (tick_no == T_FULL) begin
                        r_d.cnt = '0;
                        r_d.sh  = {maj_i, r_q.sh[DATA_W-1:1]};
                        if (r_q.idx == IDX_W'(DATA_W - 1)) r_d.state = ST_STOP;
                        else                               r_d.idx   = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = tick_no;
                    end
                end
                ST_STOP: begin
                    if (tick_no == load_at) begin
                        load_o    = 1'b1;
                        load_fe_o = check_en && !maj_i;
                    end
                    if (tick_no == end_at) begin
                        r_d.state = ST_IDLE;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = tick_no;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, cnt: '0, idx: '0, sh: '0, prev: 1'b1};
        else        r_q <= r_d;
    end

    assign data_o = r_q.sh;

    // R12: a frame only begins after a high tick followed by a low tick
    p_start_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_START && $past(r_q.state) == ST_IDLE) |->
            ($past(r_q.prev) && !$past(rx_i)));

    // R4: the bit-period counter never runs past the longest stop field
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= T_TWO);

endmodule

// File: rtl/uart_srx_flags.sv
module uart_srx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_fe_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              fe_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              fe;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (load_i)    f_d.data = data_i;
        if (load_i)    f_d.valid = 1'b1;
        else if (rd_i) f_d.valid = 1'b0;
        if (load_i && load_fe_i) f_d.fe = 1'b1;
        else if (clr_i)          f_d.fe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign data_o  = f_q.data;
    assign valid_o = f_q.valid;
    assign fe_o    = f_q.fe;

    // R9: the error flag can only rise together with a byte load
    p_fe_with_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.fe) |-> $past(load_i) && $rose(f_q.valid) || $past(load_i));

    // R10: the error flag only falls after a clear strobe
    p_fe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_q.fe) |-> $past(clr_i));

    // R11: a read strobe with no concurrent load drops the valid flag
    p_valid_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> !f_q.valid);

    // R4: the valid flag rises only from a frame completion
    p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.valid) |-> $past(load_i));

endmodule

// File: rtl/uart_stop_rx.sv
module uart_stop_rx
    import uart_srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        stop_sel,
    input  logic              rd_stb,
    input  logic              fe_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_fe
);

    logic rx_s, maj, cap, load, load_fe;
    logic [DATA_W-1:0] shift_data;

    uart_srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (rxd),
        .q_o  (rx_s)
    );

    uart_srx_vote u_vote (
        .clk  (clk),
        .rst_n(rst_n),
        .cap_i(cap),
        .bit_i(rx_s),
        .maj_o(maj)
    );

    uart_srx_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick16),
        .rx_i     (rx_s),
        .maj_i    (maj),
        .mode_i   (stop_mode_e'(stop_sel)),
        .cap_o    (cap),
        .load_o   (load),
        .load_fe_o(load_fe),
        .data_o   (shift_data)
    );

    uart_srx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .load_fe_i(load_fe),
        .data_i   (shift_data),
        .rd_i     (rd_stb),
        .clr_i    (fe_clr),
        .data_o   (rx_data),
        .valid_o  (rx_valid),
        .fe_o     (rx_fe)
    );

    // R7: with a half-bit stop field the error flag never rises
    p_half_no_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_fe) |-> ($past(stop_sel) != 2'b01));

endmodule

// File: tb/uart_stop_rx_tb.sv
module uart_stop_rx_tb;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
    logic       rd_stb = 1'b0, fe_clr = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic [7:0] rx_data;
    logic       rx_valid, rx_fe;

    uart_stop_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick), .rxd(rxd), .stop_sel(stop_sel),
        .rd_stb(rd_stb), .fe_clr(fe_clr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_fe(rx_fe)
    );

    always #2 clk = ~clk;

    int unsigned div, tcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            div <= 0; tick <= 1'b0; tcnt <= 0;
        end else begin
            div  <= (div == 3) ? 0 : div + 1;
            tick <= (div == 3);
            if (tick) tcnt <= tcnt + 1;
        end
    end

    typedef struct {
        logic [7:0]  data;
        logic        fe;
        int unsigned at;
        bit          keep;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0, fails = 0;
    bit   model_fe = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic step(input logic lvl);
        rxd = lvl;
        @(posedge clk iff tick);
        #1;
    endtask

    function automatic int stop_len(input logic [1:0] m);
        case (m)
            2'b01:   return 8;
            2'b11:   return 24;
            default: return 16;
        endcase
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] m,
                        input logic [31:0] sv, input bit ffe, input bit keep,
                        input bit glitch, input string tag);
        exp_t e;
        step(1'b1);
        stop_sel = m;
        model_fe = model_fe | ffe;
        e.data = d;
        e.fe   = model_fe;
        e.at   = tcnt + 144 + stop_len(m);
        e.keep = keep;
        e.tag  = tag;
        q.push_back(e);
        if (!keep) model_fe = 1'b0;
        for (int t = 0; t < 16; t++) step(1'b0);
        for (int i = 0; i < 8; i++) begin
            for (int t = 1; t <= 16; t++) begin
                logic lvl;
                lvl = d[i];
                if (glitch && i == 3 && t == 9) lvl = ~lvl;
                step(lvl);
            end
        end
        for (int t = 0; t < 32; t++) step(sv[t]);
        for (int t = 0; t < 3; t++) step(1'b1);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R12", "unexpected byte", rx_data, -1);
                    e.keep = 1'b0;
                end else begin
                    e = q.pop_front();
                    chk(rx_data == e.data, "R2/R9", "data", rx_data, e.data);
                    chk(rx_fe == e.fe, e.tag, "framing flag", rx_fe, e.fe);
                    chk(tcnt == e.at, "R4", "valid tick", tcnt, e.at);
                end
                rd_stb = 1'b1;
                fe_clr = !e.keep;
                @(negedge clk);
                rd_stb = 1'b0;
                fe_clr = 1'b0;
                chk(rx_valid == 1'b0, "R11", "valid after read", rx_valid, 0);
                chk(rx_fe == e.keep, "R10", "flag after strobes", rx_fe, e.keep);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", "timeout", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(rx_valid == 1'b0, "R1", "valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R1", "valid after reset", rx_valid, 0);
        chk(rx_fe == 1'b0, "R1", "fe after reset", rx_fe, 0);
        chk(rx_data == 8'h00, "R1", "data after reset", rx_data, 0);
        for (int t = 0; t < 4; t++) step(1'b1);

        send(8'hA5, 2'b00, 32'hFFFF_FFFF, 0, 0, 0, "R5");
        send(8'h3C, 2'b00, 32'hFFFF_FFFF, 0, 0, 1, "R2");
        // R3: short low pulse is a false start
        step(1'b1);
        for (int t = 0; t < 6; t++) step(1'b0);
        for (int t = 0; t < 200; t++) step(1'b1);
        chk(rx_valid == 1'b0, "R3", "false start delivered byte", rx_valid, 0);
        send(8'h5A, 2'b00, 32'hFFFF_0000, 1, 0, 0, "R9");
        send(8'h81, 2'b00, 32'hFFFF_FEFF, 0, 0, 0, "R5");
        send(8'h7E, 2'b00, 32'hFFFF_FE7F, 1, 0, 0, "R5");
        send(8'hC3, 2'b11, 32'hFFFC_7FFF, 1, 0, 0, "R6");
        send(8'h18, 2'b11, 32'hFFFF_FF00, 0, 0, 0, "R6");
        send(8'hF0, 2'b01, 32'h0000_0000, 0, 0, 0, "R7");
        send(8'h0F, 2'b10, 32'h0000_FFFF, 0, 0, 0, "R8");
        send(8'h99, 2'b10, 32'hFFFF_0000, 1, 0, 0, "R8");
        send(8'h66, 2'b00, 32'hFFFF_0000, 1, 1, 0, "R9");
        send(8'h11, 2'b00, 32'hFFFF_FFFF, 0, 0, 0, "R10");
        send(8'h00, 2'b11, 32'hFFFF_FFFF, 0, 0, 0, "R6");

        for (int t = 0; t < 40; t++) step(1'b1);
        chk(q.size() == 0, "R4", "bytes never delivered", q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule